// File: doc/BRIEF.md
# AUX Batch Request Sequencer

This block executes a batch of auxiliary-channel requests that software has packed into a shared command FIFO. Software fills the FIFO image with back-to-back requests and then writes the control word with its start bit set. Each request begins with a 4-byte header. A write request is followed by its payload bytes; a read request has the header only. The sequencer reads the headers one after another and presents each request on a downstream valid/ready request channel, which stands in for the serial AUX line. It then streams the write payload out, or collects the read reply bytes and writes them back into the FIFO, and waits for a completion code for each request.

The control word holds the number of requests minus one in its low `CNT_W` bits. Bit `CNT_W` marks the whole batch as I2C-over-AUX, since native and I2C requests never share a batch. Bit `CNT_W+1` starts the batch. A readable counter reports how many requests finished successfully. The first failing request ends the batch. One registered event pulse tells the interrupt block either that the whole batch finished or which kind of failure stopped it.

All three streams follow the same rules. The source keeps valid asserted and holds its payload stable until it sees ready, and a transfer takes place on a clock edge where both are high. The sequencer applies back-pressure on the read-reply and completion channels simply by leaving ready low outside the states that consume them. It accepts back-pressure on the request and write-payload channels for any number of cycles. The FIFO read port has one cycle of latency.

Top module: `aux_batch_sequencer`

## Requirements
- R1: After reset `busy`, `req_valid`, `wdat_valid`, `fifo_wr_en` and `evt_flags` are low, and `ctl_q` and `xact_count` are zero.
- R2: A control write while idle loads `ctl_wdata` into `ctl_q`. If bit 9 (start) is set, the batch starts and `busy` rises on the same edge. Bits 7:0 give the request count minus one, and bit 8 selects I2C mode for every request, shown on `req_i2c`.
- R3: Each header is decoded as follows. Byte 0 bits 3:0 are address bits 19:16, and byte 0 bit 4 set means a read. Byte 1 is address bits 15:8, byte 2 is address bits 7:0, and byte 3 is the transfer length minus one. The next header follows directly after the previous request's header (for a read) or after its payload (for a write).
- R4: A write request streams the len+1 bytes that follow its header, in FIFO order, on `wdat_byte`, with `wdat_last` set only on the final byte.
- R5: A read request accepts len+1 reply bytes. The replies of one batch are written through the FIFO write port to consecutive entries, starting at entry 0 and following request order.
- R6: While `req_valid` or `wdat_valid` is high and not accepted, the signal stays high and its payload stays stable.
- R7: Completion code 0 counts the request in `xact_count`. When the last request completes with code 0, `evt_flags` bit 0 pulses for one cycle and `busy` falls on the same edge.
- R8: The first nonzero completion code ends the batch. No further request is issued, `xact_count` keeps the number of successes, and bit 0 of `evt_flags` does not pulse.
- R9: Failure codes map to event bits as follows: 1 (bad address) to bit 1, 2 (timeout) to bit 2, and 3 (native NACK or defer) to bit 3. Code 4 (I2C NACK) maps to bit 4 and code 5 (I2C defer) to bit 5 in an I2C batch; in a native batch, codes 4 and 5 map to bit 3. Codes 6 and 7 map to bit 3.
- R10: Control writes during a batch are ignored: `ctl_q` keeps its value and no second batch starts.
- R11: `xact_count` clears only when a batch starts, and holds its value while idle, including after software writes 0 to the control word.
- R12: `evt_flags` has at most one bit set and pulses for a single cycle for each batch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | CNT_W+2 | Control word: count-1, I2C mode, start |
| ctl_q | output | CNT_W+2 | Stored control word |
| busy | output | 1 | Batch in progress |
| xact_count | output | CNT_W+1 | Requests completed successfully in the current or last batch |
| fifo_rd_en | output | 1 | FIFO read request |
| fifo_rd_addr | output | FIFO_AW | FIFO read entry |
| fifo_rd_data | input | 8 | FIFO read byte, one cycle after the request |
| fifo_wr_en | output | 1 | Reply byte write strobe |
| fifo_wr_addr | output | FIFO_AW | Reply byte entry |
| fifo_wr_data | output | 8 | Reply byte |
| req_valid | output | 1 | Request header valid |
| req_ready | input | 1 | Request header accepted |
| req_read | output | 1 | Request is a read |
| req_i2c | output | 1 | Request uses I2C-over-AUX |
| req_addr | output | 20 | Request address |
| req_len | output | 8 | Transfer length minus one |
| wdat_valid | output | 1 | Write payload byte valid |
| wdat_ready | input | 1 | Write payload byte accepted |
| wdat_byte | output | 8 | Write payload byte |
| wdat_last | output | 1 | Final payload byte of the request |
| rdat_valid | input | 1 | Read reply byte valid |
| rdat_ready | output | 1 | Read reply byte accepted |
| rdat_byte | input | 8 | Read reply byte |
| cpl_valid | input | 1 | Completion code valid |
| cpl_ready | output | 1 | Completion code accepted |
| cpl_code | input | 3 | Completion code, 0 meaning success |
| evt_flags | output | 6 | One-cycle event pulse to the interrupt block |

## Verification
The hardest case to reach is a control write that arrives while a batch is still in flight. The bench's downstream model holds `req_ready` low for many cycles, so the start bit is rewritten at a moment when the sequencer is provably busy. The bench then confirms that the stored word does not change and that no second header ever appears. Early termination is reached by scripting a failing completion code partway through a batch whose FIFO image still holds more requests. Any request issued after the failure then shows up as an unexpected header in the scoreboard.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;

  localparam int ADDR_W = 20;
  localparam int LEN_W  = 8;
  localparam int EVT_W  = 6;

  localparam int EVT_DONE      = 0;
  localparam int EVT_BAD_ADDR  = 1;
  localparam int EVT_TIMEOUT   = 2;
  localparam int EVT_NACK_DEF  = 3;
  localparam int EVT_I2C_NACK  = 4;
  localparam int EVT_I2C_DEFER = 5;

  typedef enum logic [2:0] {
    CPL_OK        = 3'd0,
    CPL_BAD_ADDR  = 3'd1,
    CPL_TIMEOUT   = 3'd2,
    CPL_NACK_DEF  = 3'd3,
    CPL_I2C_NACK  = 3'd4,
    CPL_I2C_DEFER = 3'd5
  } cpl_code_e;

  typedef struct packed {
    logic              is_read;
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len_m1;
  } req_hdr_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HRD,
    ST_HCAP,
    ST_REQ,
    ST_WRD,
    ST_WCAP,
    ST_WOUT,
    ST_RDAT,
    ST_CPL
  } seq_state_e;

endpackage

// File: rtl/aux_seq_hdr.sv
module aux_seq_hdr
  import aux_seq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap_en,
  input  logic [1:0]     cap_idx,
  input  logic [7:0]     cap_byte,
  output req_hdr_t       hdr
);

  localparam int NBYTES = 4;

  logic [4:0]       lead_q;
  logic [2:0][7:0]  tail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lead_q <= '0;
    end else if (cap_en && cap_idx == 2'd0) begin
      lead_q <= cap_byte[4:0];
    end
  end

  for (genvar gi = 1; gi < NBYTES; gi++) begin : g_tail
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tail_q[gi-1] <= '0;
      end else if (cap_en && cap_idx == 2'(gi)) begin
        tail_q[gi-1] <= cap_byte;
      end
    end
  end

  always_comb begin
    hdr.is_read = lead_q[4];
    hdr.addr    = {lead_q[3:0], tail_q[0], tail_q[1]};
    hdr.len_m1  = tail_q[2];
  end

endmodule

// File: rtl/aux_seq_outcome.sv
module aux_seq_outcome
  import aux_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_fire,
  input  logic             err_fire,
  input  logic [2:0]       code,
  input  logic             i2c_mode,
  output logic [EVT_W-1:0] evt
);

  logic [EVT_W-1:0] evt_d;

  always_comb begin
    evt_d = '0;
    if (done_fire) begin
      evt_d[EVT_DONE] = 1'b1;
    end else if (err_fire) begin
      unique case (code)
        CPL_BAD_ADDR:  evt_d[EVT_BAD_ADDR] = 1'b1;
        CPL_TIMEOUT:   evt_d[EVT_TIMEOUT]  = 1'b1;
        CPL_I2C_NACK:  evt_d[i2c_mode ? EVT_I2C_NACK  : EVT_NACK_DEF] = 1'b1;
        CPL_I2C_DEFER: evt_d[i2c_mode ? EVT_I2C_DEFER : EVT_NACK_DEF] = 1'b1;
        default:       evt_d[EVT_NACK_DEF] = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) evt <= '0;
    else        evt <= evt_d;
  end

endmodule

// File: rtl/aux_batch_sequencer.sv
module aux_batch_sequencer
  import aux_seq_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int FIFO_AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr,
  input  logic [CNT_W+1:0]   ctl_wdata,
  output logic [CNT_W+1:0]   ctl_q,
  output logic               busy,
  output logic [CNT_W:0]     xact_count,
  output logic               fifo_rd_en,
  output logic [FIFO_AW-1:0] fifo_rd_addr,
  input  logic [7:0]         fifo_rd_data,
  output logic               fifo_wr_en,
  output logic [FIFO_AW-1:0] fifo_wr_addr,
  output logic [7:0]         fifo_wr_data,
  output logic               req_valid,
  input  logic               req_ready,
  output logic               req_read,
  output logic               req_i2c,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [LEN_W-1:0]   req_len,
  output logic               wdat_valid,
  input  logic               wdat_ready,
  output logic [7:0]         wdat_byte,
  output logic               wdat_last,
  input  logic               rdat_valid,
  output logic               rdat_ready,
  input  logic [7:0]         rdat_byte,
  input  logic               cpl_valid,
  output logic               cpl_ready,
  input  logic [2:0]         cpl_code,
  output logic [EVT_W-1:0]   evt_flags
);

  localparam int CTL_W   = CNT_W + 2;
  localparam int BIT_I2C = CNT_W;
  localparam int BIT_GO  = CNT_W + 1;

  seq_state_e         st_q;
  logic [CNT_W-1:0]   cnt_m1_q;
  logic               i2c_q;
  logic [FIFO_AW-1:0] rd_ptr_q;
  logic [FIFO_AW-1:0] rx_ptr_q;
  logic [1:0]         hidx_q;
  logic [LEN_W-1:0]   bcnt_q;
  logic [7:0]         wbyte_q;
  logic [CNT_W:0]     xact_q;
  logic [CTL_W-1:0]   ctl_reg_q;
  req_hdr_t           hdr;

  logic start;
  logic cpl_fire;
  logic cpl_ok;
  logic last_xact;
  logic done_fire;
  logic err_fire;
  logic rd_beat;
  logic bcnt_end;

  // Stage decode
  assign start     = ctl_wr && (st_q == ST_IDLE) && ctl_wdata[BIT_GO];
  assign cpl_ready = (st_q == ST_CPL) || (st_q == ST_RDAT);
  assign cpl_fire  = cpl_valid && cpl_ready;
  assign cpl_ok    = (cpl_code == CPL_OK);
  assign last_xact = (xact_q == {1'b0, cnt_m1_q});
  assign done_fire = cpl_fire && cpl_ok && last_xact;
  assign err_fire  = cpl_fire && !cpl_ok;
  assign bcnt_end  = (bcnt_q == hdr.len_m1);

  assign rdat_ready = (st_q == ST_RDAT) && !cpl_valid;
  assign rd_beat    = rdat_valid && rdat_ready;

  // Outward signals
  assign busy         = (st_q != ST_IDLE);
  assign ctl_q        = ctl_reg_q;
  assign xact_count   = xact_q;
  assign fifo_rd_en   = (st_q == ST_HRD) || (st_q == ST_WRD);
  assign fifo_rd_addr = rd_ptr_q;
  assign fifo_wr_en   = rd_beat;
  assign fifo_wr_addr = rx_ptr_q;
  assign fifo_wr_data = rdat_byte;
  assign req_valid    = (st_q == ST_REQ);
  assign req_read     = hdr.is_read;
  assign req_i2c      = i2c_q;
  assign req_addr     = hdr.addr;
  assign req_len      = hdr.len_m1;
  assign wdat_valid   = (st_q == ST_WOUT);
  assign wdat_byte    = wbyte_q;
  assign wdat_last    = bcnt_end;

  aux_seq_hdr u_hdr (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (st_q == ST_HCAP),
    .cap_idx  (hidx_q),
    .cap_byte (fifo_rd_data),
    .hdr      (hdr)
  );

  aux_seq_outcome u_outcome (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_fire (done_fire),
    .err_fire  (err_fire),
    .code      (cpl_code),
    .i2c_mode  (i2c_q),
    .evt       (evt_flags)
  );

  // Control word: writable only while idle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_reg_q <= '0;
      cnt_m1_q  <= '0;
      i2c_q     <= 1'b0;
    end else if (ctl_wr && st_q == ST_IDLE) begin
      ctl_reg_q <= ctl_wdata;
      if (ctl_wdata[BIT_GO]) begin
        cnt_m1_q <= ctl_wdata[CNT_W-1:0];
        i2c_q    <= ctl_wdata[BIT_I2C];
      end
    end
  end

  // Transaction counter
  always_ff @(posedge clk) begin
    if (!rst_n)                 xact_q <= '0;
    else if (start)             xact_q <= '0;
    else if (cpl_fire && cpl_ok) xact_q <= xact_q + 1'b1;
  end

  // Reply write pointer
  always_ff @(posedge clk) begin
    if (!rst_n)       rx_ptr_q <= '0;
    else if (start)   rx_ptr_q <= '0;
    else if (rd_beat) rx_ptr_q <= rx_ptr_q + 1'b1;
  end

  // Sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      rd_ptr_q <= '0;
      hidx_q   <= '0;
      bcnt_q   <= '0;
      wbyte_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            rd_ptr_q <= '0;
            hidx_q   <= '0;
            st_q     <= ST_HRD;
          end
        end
        ST_HRD: st_q <= ST_HCAP;
        ST_HCAP: begin
          rd_ptr_q <= rd_ptr_q + 1'b1;
          hidx_q   <= hidx_q + 1'b1;
          st_q     <= (hidx_q == 2'd3) ? ST_REQ : ST_HRD;
        end
        ST_REQ: begin
          if (req_ready) begin
            bcnt_q <= '0;
            st_q   <= hdr.is_read ? ST_RDAT : ST_WRD;
          end
        end
        ST_WRD: st_q <= ST_WCAP;
        ST_WCAP: begin
          wbyte_q  <= fifo_rd_data;
          rd_ptr_q <= rd_ptr_q + 1'b1;
          st_q     <= ST_WOUT;
        end
        ST_WOUT: begin
          if (wdat_ready) begin
            if (bcnt_end) begin
              st_q <= ST_CPL;
            end else begin
              bcnt_q <= bcnt_q + 1'b1;
              st_q   <= ST_WRD;
            end
          end
        end
        ST_RDAT: begin
          if (cpl_fire) begin
            hidx_q <= '0;
            st_q   <= (cpl_ok && !last_xact) ? ST_HRD : ST_IDLE;
          end else if (rd_beat) begin
            bcnt_q <= bcnt_q + 1'b1;
            if (bcnt_end) st_q <= ST_CPL;
          end
        end
        ST_CPL: begin
          if (cpl_fire) begin
            hidx_q <= '0;
            st_q   <= (cpl_ok && !last_xact) ? ST_HRD : ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/aux_seq_chk.sv
module aux_seq_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr,
  input logic [CNT_W+1:0] ctl_wdata,
  input logic [CNT_W+1:0] ctl_q,
  input logic             busy,
  input logic [CNT_W:0]   xact_count,
  input logic             req_valid,
  input logic             req_ready,
  input logic [19:0]      req_addr,
  input logic [7:0]       req_len,
  input logic             req_read,
  input logic             wdat_valid,
  input logic             wdat_ready,
  input logic [7:0]       wdat_byte,
  input logic             wdat_last,
  input logic             fifo_wr_en,
  input logic             rdat_valid,
  input logic [5:0]       evt_flags
);

  localparam int BIT_GO = CNT_W + 1;

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                   $stable(req_len) && $stable(req_read)));

  assert_wdat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wdat_valid && !wdat_ready) |=> (wdat_valid && $stable(wdat_byte) &&
                                     $stable(wdat_last)));

  assert_reply_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_en |-> (rdat_valid && busy));

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_flags[0] |-> !busy);

  assert_end_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (evt_flags != 6'd0));

  assert_ctl_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_wr) |=> $stable(ctl_q));

  assert_count_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(ctl_wr && ctl_wdata[BIT_GO])) |=> $stable(xact_count));

  assert_evt_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(evt_flags));

endmodule

bind aux_batch_sequencer aux_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_wr     (ctl_wr),
  .ctl_wdata  (ctl_wdata),
  .ctl_q      (ctl_q),
  .busy       (busy),
  .xact_count (xact_count),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .req_len    (req_len),
  .req_read   (req_read),
  .wdat_valid (wdat_valid),
  .wdat_ready (wdat_ready),
  .wdat_byte  (wdat_byte),
  .wdat_last  (wdat_last),
  .fifo_wr_en (fifo_wr_en),
  .rdat_valid (rdat_valid),
  .evt_flags  (evt_flags)
);

// File: tb/aux_batch_sequencer_tb.sv
module aux_batch_sequencer_tb;

  typedef struct packed {
    logic        rd;
    logic        i2c;
    logic [19:0] a;
    logic [7:0]  l;
  } exp_hdr_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [9:0]  ctl_wdata = '0;
  logic [9:0]  ctl_q;
  logic        busy;
  logic [8:0]  xact_count;
  logic        fifo_rd_en;
  logic [7:0]  fifo_rd_addr;
  logic [7:0]  fifo_rd_data = '0;
  logic        fifo_wr_en;
  logic [7:0]  fifo_wr_addr;
  logic [7:0]  fifo_wr_data;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic        req_read;
  logic        req_i2c;
  logic [19:0] req_addr;
  logic [7:0]  req_len;
  logic        wdat_valid;
  logic        wdat_ready = 1'b0;
  logic [7:0]  wdat_byte;
  logic        wdat_last;
  logic        rdat_valid = 1'b0;
  logic        rdat_ready;
  logic [7:0]  rdat_byte = '0;
  logic        cpl_valid = 1'b0;
  logic        cpl_ready;
  logic [2:0]  cpl_code = '0;
  logic [5:0]  evt_flags;

  int n_cmp = 0;
  int n_bad = 0;
  int wp = 0;
  int req_stall = 0;
  logic cur_i2c = 1'b0;

  logic [7:0] mem    [256];
  logic [7:0] rx_mem [256];
  exp_hdr_t   exp_hdr_q[$];
  logic [7:0] exp_w_q[$];
  logic [2:0] exp_code_q[$];
  logic [7:0] exp_rx_q[$];
  logic [5:0] ev_q[$];

  always #5ns clk = ~clk;

  aux_batch_sequencer u_dut (.*);

  always @(posedge clk) if (fifo_rd_en) fifo_rd_data <= mem[fifo_rd_addr];
  always @(posedge clk) if (fifo_wr_en) rx_mem[fifo_wr_addr] <= fifo_wr_data;
  always @(negedge clk) if (rst_n && evt_flags != 6'd0) ev_q.push_back(evt_flags);

  function automatic logic [7:0] pat(input logic [19:0] a, input int i);
    return (a[7:0] ^ 8'(i * 29)) + 8'h07;
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Driver: lays out a request in the FIFO image and queues expectations
  task automatic add_wr(input logic [19:0] a, input int n, input logic [7:0] seed,
                        input bit served, input logic [2:0] code);
    mem[8'(wp)]   = {4'h0, a[19:16]};
    mem[8'(wp+1)] = a[15:8];
    mem[8'(wp+2)] = a[7:0];
    mem[8'(wp+3)] = 8'(n - 1);
    for (int i = 0; i < n; i++) mem[8'(wp+4+i)] = seed + 8'(i);
    wp += 4 + n;
    if (served) begin
      exp_hdr_q.push_back('{rd: 1'b0, i2c: cur_i2c, a: a, l: 8'(n - 1)});
      for (int i = 0; i < n; i++) exp_w_q.push_back(seed + 8'(i));
      exp_code_q.push_back(code);
    end
  endtask

  task automatic add_rd(input logic [19:0] a, input int n, input bit served,
                        input logic [2:0] code);
    mem[8'(wp)]   = {4'h1, a[19:16]};
    mem[8'(wp+1)] = a[15:8];
    mem[8'(wp+2)] = a[7:0];
    mem[8'(wp+3)] = 8'(n - 1);
    wp += 4;
    if (served) begin
      exp_hdr_q.push_back('{rd: 1'b1, i2c: cur_i2c, a: a, l: 8'(n - 1)});
      exp_code_q.push_back(code);
      if (code == 3'd0)
        for (int i = 0; i < n; i++) exp_rx_q.push_back(pat(a, i));
    end
  endtask

  task automatic ctl_write(input logic [9:0] v);
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  // Monitor / downstream responder: compares each request against the queue
  task automatic serve();
    exp_hdr_t e;
    logic [2:0] code;
    logic [19:0] a;
    int n;
    if (exp_hdr_q.size() == 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R8 unexpected request: actual addr %h expected none", req_addr);
      e = '{rd: req_read, i2c: req_i2c, a: req_addr, l: req_len};
      code = 3'd2;
    end else begin
      e = exp_hdr_q.pop_front();
      code = exp_code_q.pop_front();
      chk("R3", "req_read", 32'(req_read), 32'(e.rd));
      chk("R3", "req_addr", 32'(req_addr), 32'(e.a));
      chk("R3", "req_len", 32'(req_len), 32'(e.l));
      chk("R2", "req_i2c", 32'(req_i2c), 32'(e.i2c));
    end
    a = e.a;
    n = int'(e.l) + 1;
    repeat (req_stall) @(negedge clk);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    if (!e.rd) begin
      for (int i = 0; i < n; i++) begin
        while (!wdat_valid) @(negedge clk);
        if (exp_w_q.size() > 0) chk("R4", "wdat_byte", 32'(wdat_byte), 32'(exp_w_q.pop_front()));
        chk("R4", "wdat_last", 32'(wdat_last), 32'(i == n - 1));
        wdat_ready = 1'b1;
        @(negedge clk);
        wdat_ready = 1'b0;
      end
    end else if (code == 3'd0) begin
      for (int i = 0; i < n; i++) begin
        if (i == 1) @(negedge clk);
        rdat_valid = 1'b1;
        rdat_byte = pat(a, i);
        while (!rdat_ready) @(negedge clk);
        @(negedge clk);
        rdat_valid = 1'b0;
      end
    end
    cpl_valid = 1'b1;
    cpl_code = code;
    while (!cpl_ready) @(negedge clk);
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && req_valid) serve();
    end
  end

  task automatic run_batch(input string tag, input logic [9:0] ctl, input logic [5:0] exp_evt,
                           input int exp_cnt, input bit poke);
    int guard;
    ev_q.delete();
    ctl_write(ctl);
    chk("R2", {tag, " ctl_q"}, 32'(ctl_q), 32'(ctl));
    chk("R2", {tag, " busy"}, 32'(busy), 32'd1);
    if (poke) begin
      repeat (2) @(negedge clk);
      ctl_write(10'h3FF);
      chk("R10", {tag, " ctl_q after write while busy"}, 32'(ctl_q), 32'(ctl));
    end
    guard = 0;
    while (busy && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    chk("R12", {tag, " event count"}, 32'(ev_q.size()), 32'd1);
    if (ev_q.size() > 0) chk("R9", {tag, " event"}, 32'(ev_q[0]), 32'(exp_evt));
    chk("R8", {tag, " requests left"}, 32'(exp_hdr_q.size()), 32'd0);
    chk("R7", {tag, " xact_count"}, 32'(xact_count), 32'(exp_cnt));
    for (int i = 0; i < exp_rx_q.size(); i++)
      chk("R5", {tag, " reply byte"}, 32'(rx_mem[i]), 32'(exp_rx_q[i]));
    exp_rx_q.delete();
    exp_hdr_q.delete();
    exp_w_q.delete();
    exp_code_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "ctl_q", 32'(ctl_q), 0);
    chk("R1", "xact_count", 32'(xact_count), 0);
    chk("R1", "outputs", 32'({req_valid, wdat_valid, fifo_wr_en, evt_flags}), 0);

    // Native write then read, full success (R3 R4 R5 R7)
    wp = 0; cur_i2c = 1'b0;
    add_wr(20'h12345, 3, 8'hA0, 1, 3'd0);
    add_rd(20'h00200, 4, 1, 3'd0);
    run_batch("native ok", 10'h201, 6'h01, 2, 0);

    // I2C batch of three reads with stall, replies packed from entry 0 (R5)
    wp = 0; cur_i2c = 1'b1; req_stall = 2;
    add_rd(20'h00050, 2, 1, 3'd0);
    add_rd(20'h00051, 1, 1, 3'd0);
    add_rd(20'h80052, 3, 1, 3'd0);
    run_batch("i2c reads", 10'h302, 6'h01, 3, 0);
    req_stall = 0;

    // Timeout on second write stops the batch (R8)
    wp = 0; cur_i2c = 1'b0;
    add_wr(20'h00100, 2, 8'h10, 1, 3'd0);
    add_wr(20'h00101, 1, 8'h20, 1, 3'd2);
    add_wr(20'h00102, 1, 8'h30, 0, 3'd0);
    run_batch("timeout stop", 10'h202, 6'h04, 1, 0);

    // I2C defer on first read (R9)
    wp = 0; cur_i2c = 1'b1;
    add_rd(20'h00050, 1, 1, 3'd5);
    add_rd(20'h00060, 1, 0, 3'd0);
    run_batch("i2c defer", 10'h301, 6'h20, 0, 0);

    // I2C NACK code in a native batch folds to bit 3 (R9)
    wp = 0; cur_i2c = 1'b0;
    add_rd(20'h00070, 2, 1, 3'd4);
    run_batch("native i2c code", 10'h200, 6'h08, 0, 0);

    // Bad address on read after good write (R9)
    wp = 0; cur_i2c = 1'b0;
    add_wr(20'h0F00F, 2, 8'h55, 1, 3'd0);
    add_rd(20'h00080, 2, 1, 3'd1);
    run_batch("bad addr", 10'h201, 6'h02, 1, 0);

    // I2C NACK on a write in an I2C batch (R9)
    wp = 0; cur_i2c = 1'b1;
    add_wr(20'h00050, 1, 8'h77, 1, 3'd4);
    run_batch("i2c nack", 10'h300, 6'h10, 0, 0);

    // Control write during a stalled batch is ignored (R10)
    wp = 0; cur_i2c = 1'b0; req_stall = 30;
    add_rd(20'h00090, 2, 1, 3'd0);
    run_batch("busy poke", 10'h200, 6'h01, 1, 1);
    req_stall = 0;

    // Clearing the control word keeps the count (R11)
    ctl_write(10'h000);
    chk("R2", "ctl_q cleared", 32'(ctl_q), 0);
    repeat (4) @(negedge clk);
    chk("R11", "xact_count after clear", 32'(xact_count), 1);
    chk("R10", "no restart", 32'(busy), 0);

    finish_run();
  end

endmodule